// File: doc/BRIEF.md
# Tick Timer with Dual-Pin Edge Capture

This block keeps a 12-bit count that advances by one on every cycle in which the 1 µs tick enable is high. From that count it raises two periodic request pulses: a short-period one every 128 ticks and a long-period one every 1024 ticks. Software can read the low byte of the count through a small register port.

Two input pins, A and B, each pass through a two-flop synchronizer. Each pin has one capture register for rising edges and one for falling edges, so there are four in total. On an edge, the matching register stores an 8-bit window of the count. A 3-bit prescale field picks where that window sits within the 12 bits. Each capture register raises its own request flag when it loads, and a read of that register clears the flag. In hold mode, a register whose flag is still pending keeps its first value and ignores later edges until software reads it. Without hold mode, each new edge overwrites the register.

Top module: `ftc_top`

## Requirements
- R1: The 12-bit count resets to 0. It increments by one at each clock edge where `tick_i` is high, wraps from 4095 to 0, and holds its value while `tick_i` is low.
- R2: `irq_fast_o` is high for exactly the one cycle after a tick brings the count to a multiple of 128. `irq_slow_o` behaves the same way for multiples of 1024. Both are low after reset.
- R3: Address 0 reads count bits [7:0]. Address 1 is a read/write configuration byte: bits [2:0] hold the prescale and bit 3 enables hold, and both reset to 0. Addresses 6 and 7 read as 0.
- R4: A rising edge on synchronized pin A loads address 2, a falling edge on A loads address 3, a rising edge on B loads address 4, and a falling edge on B loads address 5. A pin change shows in the capture register within 3 clock edges.
- R5: With prescale n from 0 to 4, the captured byte is count bits [n+7:n]. Prescale values 5, 6 and 7 behave as 4 and give bits [11:4].
- R6: Capture registers are read-only. A write to addresses 2 to 5 leaves their contents unchanged.
- R7: With hold off, every edge overwrites its capture register. With hold on, a register whose flag is pending keeps its value and ignores further edges until it is read.
- R8: `cap_irq_o[k]` is set when capture register k loads, where k is the address minus 2. A read of that register clears the bit, but a load in the same cycle wins over the clear. All capture registers and flags reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 1 µs count enable, one clock wide per tick |
| pin_a_i | input | 1 | Capture pin A, asynchronous |
| pin_b_i | input | 1 | Capture pin B, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; clears a capture flag |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| irq_fast_o | output | 1 | 128-tick periodic request pulse |
| irq_slow_o | output | 1 | 1024-tick periodic request pulse |
| cap_irq_o | output | 4 | Per-capture-register request flags |

## Verification
The assertions assume three things about the inputs: `tick_i` is a clean single-cycle enable, a read strobe lasts one cycle, and pin levels are stable long enough to pass through the synchronizer. The stimulus drives every input at the falling clock edge and leaves at least four cycles between pin changes. It holds `tick_i` low while an edge travels to its register, so the expected window comes from a count the bench has tracked itself. Reads are always single-cycle strobes, each followed by an idle cycle.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
    localparam int unsigned CNT_W   = 12;
    localparam int unsigned CAP_W   = 8;
    localparam int unsigned NUM_PIN = 2;
    localparam int unsigned ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CNT    = 3'd0,
        ADDR_CFG    = 3'd1,
        ADDR_A_RISE = 3'd2,
        ADDR_A_FALL = 3'd3,
        ADDR_B_RISE = 3'd4,
        ADDR_B_FALL = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic       hold;
        logic [2:0] presc;
    } cfg_t;
endpackage

// File: rtl/ftc_free_cnt.sv
module ftc_free_cnt #(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned FAST_LOG = 7,
    parameter int unsigned SLOW_LOG = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_fast_o,
    output logic             irq_slow_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fast;
        logic             slow;
    } state_t;

    state_t state_d, state_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        state_d = state_q;
        cnt_inc = state_q.cnt + 1'b1;
        state_d.fast = 1'b0;
        state_d.slow = 1'b0;
        if (tick_i) begin
            state_d.cnt  = cnt_inc;
            state_d.fast = (cnt_inc[FAST_LOG-1:0] == '0);
            state_d.slow = (cnt_inc[SLOW_LOG-1:0] == '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign cnt_o      = state_q.cnt;
    assign irq_fast_o = state_q.fast;
    assign irq_slow_o = state_q.slow;

    assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
    assert_cnt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(cnt_o));
    assert_fast_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_fast_o |-> (cnt_o[FAST_LOG-1:0] == '0) && $past(tick_i));
    assert_slow_implies_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_slow_o |-> irq_fast_o);
endmodule

// File: rtl/ftc_edge_det.sv
module ftc_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.s1   = pin_i;
        state_d.s2   = state_q.s1;
        state_d.prev = state_q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign rise_o = state_q.s2 & ~state_q.prev;
    assign fall_o = ~state_q.s2 & state_q.prev;

    assert_rise_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
    assert_fall_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);
endmodule

// File: rtl/ftc_cap_slot.sv
module ftc_cap_slot #(
    parameter int unsigned CAP_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             hold_i,
    input  logic [CAP_W-1:0] value_i,
    input  logic             rd_i,
    output logic [CAP_W-1:0] data_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CAP_W-1:0] data;
        logic             flag;
    } state_t;

    state_t state_d, state_q;
    logic   accept;

    always_comb begin
        state_d = state_q;
        accept  = load_i && !(hold_i && state_q.flag);
        if (accept) begin
            state_d.data = value_i;
            state_d.flag = 1'b1;
        end else if (rd_i) begin
            state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign data_o = state_q.data;
    assign flag_o = state_q.flag;

    assert_load_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !(hold_i && flag_o)) |=> (data_o == $past(value_i)) && flag_o);
    assert_held_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i && flag_o) |=> $stable(data_o));
    assert_rd_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !load_i) |=> !flag_o);
endmodule

// File: rtl/ftc_top.sv
module ftc_top
    import ftc_pkg::*;
#(
    parameter int unsigned FAST_LOG = 7,
    parameter int unsigned SLOW_LOG = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              pin_a_i,
    input  logic              pin_b_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CAP_W-1:0]  reg_wdata_i,
    output logic [CAP_W-1:0]  reg_rdata_o,
    output logic              irq_fast_o,
    output logic              irq_slow_o,
    output logic [2*NUM_PIN-1:0] cap_irq_o
);
    localparam int unsigned NUM_CAP  = 2 * NUM_PIN;
    localparam int unsigned MAX_SH   = CNT_W - CAP_W;
    localparam int unsigned CAP_BASE = 2;

    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t state_d, state_q;

    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cnt_shifted;
    logic [CAP_W-1:0]   cap_val;
    logic [NUM_PIN-1:0] pins, rise, fall;
    logic [NUM_CAP-1:0] load, slot_rd, flags;
    logic [CAP_W-1:0]   cap_data [NUM_CAP];
    logic [3:0]         unused_wdata;

    assign unused_wdata = reg_wdata_i[CAP_W-1:4];
    assign pins = {pin_b_i, pin_a_i};

    ftc_free_cnt #(
        .CNT_W(CNT_W), .FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)
    ) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
        .cnt_o(cnt), .irq_fast_o(irq_fast_o), .irq_slow_o(irq_slow_o)
    );

    always_comb begin
        int unsigned sh;
        sh = (int'(state_q.cfg.presc) > int'(MAX_SH)) ? MAX_SH : int'(state_q.cfg.presc);
        cnt_shifted = cnt >> sh;
        cap_val     = cnt_shifted[CAP_W-1:0];
    end

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        ftc_edge_det u_edge (
            .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pins[p]),
            .rise_o(rise[p]), .fall_o(fall[p])
        );
        assign load[2*p]   = rise[p];
        assign load[2*p+1] = fall[p];
    end

    for (genvar k = 0; k < NUM_CAP; k++) begin : g_slot
        assign slot_rd[k] = reg_rd_i && (reg_addr_i == ADDR_W'(CAP_BASE + k));
        ftc_cap_slot #(.CAP_W(CAP_W)) u_slot (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .load_i(load[k]), .hold_i(state_q.cfg.hold), .value_i(cap_val),
            .rd_i(slot_rd[k]), .data_o(cap_data[k]), .flag_o(flags[k])
        );
    end

    always_comb begin
        state_d = state_q;
        if (reg_wr_i && reg_addr_i == ADDR_CFG) begin
            state_d.cfg = reg_wdata_i[3:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CNT: reg_rdata_o = cnt[CAP_W-1:0];
            ADDR_CFG: reg_rdata_o[3:0] = state_q.cfg;
            default: begin
                for (int k = 0; k < int'(NUM_CAP); k++) begin
                    if (reg_addr_i == ADDR_W'(CAP_BASE + k)) reg_rdata_o = cap_data[k];
                end
            end
        endcase
    end

    assign cap_irq_o = flags;

    assert_cfg_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == ADDR_CFG) |=> state_q.cfg == $past(reg_wdata_i[3:0]));
    assert_one_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(slot_rd));
    assert_flag_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load[0] |=> flags[0]);
endmodule

// File: tb/ftc_top_tb_top.sv
module ftc_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic pin_a = 1'b0, pin_b = 1'b0;
    logic wr = 1'b0, rd = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq_fast, irq_slow;
    logic [3:0] cap_irq;

    int n_chk = 0, n_fail = 0;
    int cnt = 0;
    int ps = 0;
    int q_req[$];
    logic [7:0] q_exp[$];
    logic [7:0] v1, v2;

    always #10 clk = ~clk;

    ftc_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .pin_a_i(pin_a), .pin_b_i(pin_b),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_fast_o(irq_fast), .irq_slow_o(irq_slow),
        .cap_irq_o(cap_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] win(input int c, input int p);
        int s;
        s = (p > 4) ? 4 : p;
        return 8'((c >> s) & 255);
    endfunction

    task automatic tick_n(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        cnt = (cnt + n) % 4096;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    // driver: pushes the expected value, monitor compares it
    task automatic rd_reg(input logic [2:0] a, input logic [7:0] e, input int req);
        @(negedge clk); rd = 1'b1; addr = a;
        q_req.push_back(req); q_exp.push_back(e);
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic set_pin(input bit b_pin, input logic v);
        @(negedge clk);
        if (b_pin) pin_b = v; else pin_a = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic settle;
        @(negedge clk); #5;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk); #5;
            if (rd) begin
                if (q_req.size() == 0) chk("R3 unexpected read", 1, 0);
                else begin
                    int r;
                    logic [7:0] e;
                    r = q_req.pop_front(); e = q_exp.pop_front();
                    chk($sformatf("R%0d read addr %0d", r, addr), int'(rdata), int'(e));
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R8 reset flags", int'(cap_irq), 0);
        chk("R2 reset irq", int'({irq_fast, irq_slow}), 0);
        rd_reg(3'd0, 8'h00, 1);
        rd_reg(3'd2, 8'h00, 8);
        rd_reg(3'd5, 8'h00, 8);
        wr_reg(3'd1, 8'h0D);
        rd_reg(3'd1, 8'h0D, 3);
        wr_reg(3'd1, 8'h00);
        rd_reg(3'd6, 8'h00, 3);
        rd_reg(3'd7, 8'h00, 3);

        // R2 periodic pulses
        tick_n(127);
        rd_reg(3'd0, 8'd127, 1);
        settle();
        chk("R2 fast low before 128", int'(irq_fast), 0);
        tick_n(1); #5;
        chk("R2 fast at 128", int'(irq_fast), 1);
        chk("R2 slow low at 128", int'(irq_slow), 0);
        settle();
        chk("R2 fast one cycle", int'(irq_fast), 0);
        tick_n(1023 - cnt);
        tick_n(1); #5;
        chk("R2 fast at 1024", int'(irq_fast), 1);
        chk("R2 slow at 1024", int'(irq_slow), 1);

        // R4 R5 prescale 0, rise A
        tick_n(55);
        set_pin(1'b0, 1'b1);
        settle();
        chk("R8 flag rise A", int'(cap_irq), 1);
        v1 = win(cnt, 0);
        rd_reg(3'd2, v1, 4);
        settle();
        chk("R8 flag cleared by read", int'(cap_irq), 0);

        // R5 prescale 3, fall A
        ps = 3; wr_reg(3'd1, 8'(ps));
        tick_n(85);
        set_pin(1'b0, 1'b0);
        settle();
        chk("R8 flag fall A", int'(cap_irq), 2);
        rd_reg(3'd3, win(cnt, 3), 5);

        // R5 prescale 7 clamps to 4, rise B
        ps = 7; wr_reg(3'd1, 8'(ps));
        tick_n(452);
        set_pin(1'b1, 1'b1);
        rd_reg(3'd4, win(cnt, 4), 5);

        // R5 prescale 2, fall B
        ps = 2; wr_reg(3'd1, 8'(ps));
        tick_n(301);
        set_pin(1'b1, 1'b0);
        rd_reg(3'd5, win(cnt, 2), 5);

        // R6 write to capture register ignored
        wr_reg(3'd2, 8'hFF);
        wr_reg(3'd5, 8'h00);
        rd_reg(3'd2, v1, 6);
        rd_reg(3'd5, win(cnt, 2), 6);

        // R7 overwrite without hold
        ps = 0; wr_reg(3'd1, 8'h00);
        tick_n(17);
        set_pin(1'b0, 1'b1);
        tick_n(9);
        set_pin(1'b0, 1'b0);
        v2 = win(cnt, 0);
        tick_n(33);
        set_pin(1'b0, 1'b1);
        rd_reg(3'd2, win(cnt, 0), 7);
        rd_reg(3'd3, v2, 7);

        // R7 hold mode keeps first edge
        wr_reg(3'd1, 8'h08);
        tick_n(21);
        set_pin(1'b0, 1'b0);
        v1 = win(cnt, 0);
        tick_n(14);
        set_pin(1'b0, 1'b1);
        v2 = win(cnt, 0);
        tick_n(40);
        set_pin(1'b0, 1'b0);
        tick_n(6);
        set_pin(1'b0, 1'b1);
        rd_reg(3'd3, v1, 7);
        rd_reg(3'd2, v2, 7);
        settle();
        chk("R8 flags clear after reads", int'(cap_irq), 0);
        tick_n(27);
        set_pin(1'b0, 1'b0);
        rd_reg(3'd3, win(cnt, 0), 7);

        // R1 wrap
        tick_n(4095 - cnt);
        rd_reg(3'd0, 8'hFF, 1);
        tick_n(1); #5;
        chk("R2 slow at wrap", int'(irq_slow), 1);
        rd_reg(3'd0, 8'h00, 1);

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", q_req.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule